// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block paces temperature conversions and owns the result register of a digital thermometer. A free-running tick from elsewhere on the chip is the time base. Each conversion lasts a number of ticks set by a 2-bit resolution code, and the length doubles with every extra bit of resolution. When the last tick of a conversion arrives, the block samples a 12-bit two's-complement raw reading (1/16 degree per LSB). It clears the low bits that the selected resolution does not cover and stores the value. In the cycle that follows, it raises a one-cycle done pulse that the alert logic can use.

Three operating styles come from two configuration inputs. With the power-down input low, conversions repeat back to back. With it high, the block stops after the conversion in progress ends. While stopped, a single-conversion request runs exactly one conversion. Resolution, power-down and single-conversion requests act only at conversion boundaries. A conversion already under way keeps the length and truncation it started with.

Top module: `thermo_conv_seq`

## Requirements
- R1: While reset is held and after its release, `result` reads 0 and `conv_done` stays low until the first conversion completes. With `pwr_down` low at release, the first conversion starts on the first clock edge after reset.
- R2: With `pwr_down` low, a new conversion starts on the same edge that ends the previous one, with no idle cycle between them.
- R3: A conversion lasts exactly `BASE_TICKS << res_code` tick pulses: 1x, 2x, 4x and 8x for codes 0, 1, 2 and 3. Clock cycles without `tick` do not count. `BASE_TICKS` must be at least 2.
- R4: The stored value is the raw reading with its 3 - `res_code` least significant bits forced to 0. Code 3 keeps all 12 bits, code 2 clears bit 0, code 1 clears bits 1:0 and code 0 clears bits 2:0. The kept bits, including the sign bit 11, are copied unchanged.
- R5: `result` is written on the clock edge that consumes the final tick, and `conv_done` is high for exactly the one following cycle. `result` does not change at any other time.
- R6: If `pwr_down` goes high during a conversion, that conversion completes and stores its value, and no further conversion starts.
- R7: While `pwr_down` is high, a pulse on `single_req` runs exactly one conversion and the block then stops again. A request that arrives while a conversion is running is held and starts one more conversion when the running one ends.
- R8: A `single_req` pulse while `pwr_down` is low is ignored. It neither changes the cadence nor leaves a pending conversion for a later power-down.
- R9: A change of `res_code` during a conversion does not alter that conversion's length or truncation. The new code applies from the next conversion start.
- R10: The raw reading is sampled only on the edge that consumes the final tick. The value of `raw_temp` at other times has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse; one conversion step per high cycle |
| res_code | input | 2 | Resolution select: 0..3 gives 9..12 bits |
| pwr_down | input | 1 | 1 stops conversions at the next boundary |
| single_req | input | 1 | One-cycle request for one conversion while powered down |
| raw_temp | input | DATA_W | Two's-complement raw reading from the converter |
| result | output | DATA_W | Last stored, truncated reading |
| conv_done | output | 1 | One-cycle pulse after each stored result |

## Verification
Two cases are the hardest to reach from the ports. The first is a single-conversion request that lands while power-down is already high but a conversion is still running. The second is the opposite: a request made during continuous running that must not survive into a later power-down. The bench reaches both by timing stimulus against the observed done pulse. It waits for one pulse, then places the request and the power-down change a cycle or two into the next conversion. It then counts pulses over a window well past the longest conversion. Sampling the raw reading is checked by letting the bench change `raw_temp` every cycle. The bench records the value present on the cycle of each done edge and compares it with the stored result.

// File: rtl/thermo_conv_seq.sv
module thermo_conv_seq #(
  parameter int DATA_W     = 12,
  parameter int BASE_TICKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        res_code,
  input  logic              pwr_down,
  input  logic              single_req,
  input  logic [DATA_W-1:0] raw_temp,
  output logic [DATA_W-1:0] result,
  output logic              conv_done
);
  localparam int MAX_TICKS = BASE_TICKS * 8;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             busy;
  logic             os_pend;
  logic [1:0]       cur_res;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  function automatic logic [CNT_W-1:0] len_of(input logic [1:0] r);
    return CNT_W'(BASE_TICKS) << r;
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(input logic [1:0] r);
    return {DATA_W{1'b1}} << (2'd3 - r);
  endfunction

  wire last     = busy && tick && (cnt == len - CNT_W'(1));
  wire boundary = !busy || last;
  wire os_want  = pwr_down && (os_pend || single_req);
  wire start    = boundary && (!pwr_down || os_want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      os_pend   <= 1'b0;
      cur_res   <= '0;
      cnt       <= '0;
      len       <= '0;
      result    <= '0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= last;
      if (last)
        result <= raw_temp & keep_mask(cur_res);

      if (start || !pwr_down)
        os_pend <= 1'b0;
      else if (single_req)
        os_pend <= 1'b1;

      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        cur_res <= res_code;
        len     <= len_of(res_code);
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/thermo_conv_seq_chk.sv
module thermo_conv_seq_chk #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic              single_req,
  input logic              conv_done,
  input logic [DATA_W-1:0] result,
  input logic              busy,
  input logic              os_pend,
  input logic [1:0]        cur_res,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  len
);
  logic done_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) done_seen <= 1'b0;
    else if (conv_done) done_seen <= 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_seen && !conv_done) |-> (result == '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |-> $stable(result));

  p_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> ((result & ~({DATA_W{1'b1}} << (2'd3 - $past(cur_res)))) == '0));

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len));

  p_stay_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_down && !os_pend && !single_req) |=> !busy);
endmodule

bind thermo_conv_seq thermo_conv_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .single_req(single_req),
  .conv_done(conv_done), .result(result), .busy(busy), .os_pend(os_pend),
  .cur_res(cur_res), .cnt(cnt), .len(len)
);

// File: tb/sim_thermo_conv_seq.sv
module sim_thermo_conv_seq;
  localparam int BT = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [1:0] res_code = 0;
  logic pwr_down = 0;
  logic single_req = 0;
  logic [11:0] raw_temp = 0;
  logic [11:0] result;
  logic conv_done;

  thermo_conv_seq #(.DATA_W(12), .BASE_TICKS(BT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .res_code(res_code),
    .pwr_down(pwr_down), .single_req(single_req), .raw_temp(raw_temp),
    .result(result), .conv_done(conv_done)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int tick_gap = 1, gap_cnt = 0;
  bit raw_walk = 0;
  int tick_total = 0, cyc = 0, done_cnt = 0;
  int t_prev = 0, t_last = 0, c_prev = 0, c_last = 0;
  int pulse_err = 0;
  bit prev_done = 0;
  logic [11:0] done_raw = 0;

  always @(negedge clk) begin
    cyc++;
    if (tick) tick_total++;
    if (conv_done) begin
      done_cnt++;
      t_prev = t_last; t_last = tick_total;
      c_prev = c_last; c_last = cyc;
      done_raw = raw_temp;
      if (prev_done) pulse_err++;
    end
    prev_done = conv_done;
    tick = (gap_cnt == 0);
    gap_cnt = (gap_cnt + 1 >= tick_gap) ? 0 : gap_cnt + 1;
    if (raw_walk) raw_temp = raw_temp + 12'h0B3;
  end

  function automatic logic [11:0] trunc(input logic [11:0] v, input int code);
    return v & ~((12'd1 << (3 - code)) - 12'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_dones(input int n);
    int target = done_cnt + n;
    int guard = 0;
    while (done_cnt < target && guard < 2000) begin
      step(1); guard++;
    end
  endtask

  task automatic t_reset();
    int bad = 0;
    rst_n = 0; pwr_down = 0; res_code = 3; raw_temp = 12'h190;
    step(5);
    chk(result == 0, "R1 reset result", result, 0);
    chk(conv_done == 0, "R1 reset done", conv_done, 0);
    rst_n = 1;
    while (done_cnt == 0 && cyc < 1000) begin
      step(1);
      if (done_cnt == 0 && result != 0) bad++;
    end
    chk(bad == 0, "R1 zero before first done", bad, 0);
    chk(result == 12'h190, "R1 first result", result, 12'h190);
  endtask

  task automatic t_lengths();
    raw_temp = 12'hC97;
    for (int code = 0; code < 4; code++) begin
      res_code = 2'(code);
      wait_dones(2);
      chk(t_last - t_prev == (BT << code), "R3 ticks per conversion", t_last - t_prev, BT << code);
      chk(result == trunc(12'hC97, code), "R4 truncation", result, trunc(12'hC97, code));
    end
  endtask

  task automatic t_extremes();
    res_code = 0; raw_temp = 12'h7FF;
    wait_dones(2);
    chk(result == 12'h7F8, "R4 max code 9 bits", result, 12'h7F8);
    raw_temp = 12'h800;
    wait_dones(1);
    chk(result == 12'h800, "R4 min code sign kept", result, 12'h800);
  endtask

  task automatic t_gap();
    res_code = 1; tick_gap = 3;
    wait_dones(3);
    chk(t_last - t_prev == 2 * BT, "R3 ticks with gaps", t_last - t_prev, 2 * BT);
    chk(c_last - c_prev == 6 * BT, "R2 R3 cycles back to back", c_last - c_prev, 6 * BT);
    tick_gap = 1;
    wait_dones(2);
    chk(c_last - c_prev == 2 * BT, "R2 no idle cycle", c_last - c_prev, 2 * BT);
  endtask

  task automatic t_pulse();
    logic [11:0] r;
    int bad = 0;
    int n;
    res_code = 2;
    wait_dones(1);
    r = result; n = done_cnt;
    while (done_cnt == n && cyc < 100000) begin
      step(1);
      if (done_cnt == n && result != r) bad++;
    end
    chk(bad == 0, "R5 result held between dones", bad, 0);
    chk(pulse_err == 0, "R5 done one cycle", pulse_err, 0);
  endtask

  task automatic t_resmid();
    res_code = 0; raw_temp = 12'hC97;
    wait_dones(2);
    step(1);
    res_code = 3;
    wait_dones(1);
    chk(t_last - t_prev == BT, "R9 old length kept", t_last - t_prev, BT);
    chk(result == 12'hC90, "R9 old truncation kept", result, 12'hC90);
    wait_dones(1);
    chk(t_last - t_prev == 8 * BT, "R9 new length next", t_last - t_prev, 8 * BT);
    chk(result == 12'hC97, "R9 new truncation next", result, 12'hC97);
  endtask

  task automatic t_walk();
    res_code = 2; raw_walk = 1;
    wait_dones(2);
    chk(result == trunc(done_raw, 2), "R10 sampled at final tick", result, trunc(done_raw, 2));
    wait_dones(1);
    chk(result == trunc(done_raw, 2), "R10 sampled again", result, trunc(done_raw, 2));
    raw_walk = 0;
  endtask

  task automatic t_shutdown();
    int n;
    res_code = 0; raw_temp = 12'h4B0;
    wait_dones(2);
    step(1);
    pwr_down = 1; n = done_cnt;
    step(100);
    chk(done_cnt - n == 1, "R6 one conversion then stop", done_cnt - n, 1);
    raw_temp = 12'h321;
    step(40);
    chk(result == 12'h4B0, "R6 no conversion while down", result, 12'h4B0);
  endtask

  task automatic t_oneshot();
    int n;
    res_code = 3; raw_temp = 12'h321; n = done_cnt;
    single_req = 1; step(1); single_req = 0;
    step(100);
    chk(done_cnt - n == 1, "R7 single conversion", done_cnt - n, 1);
    chk(result == 12'h321, "R7 single result", result, 12'h321);
    n = done_cnt;
    single_req = 1; step(1); single_req = 0;
    step(3);
    single_req = 1; step(1); single_req = 0;
    step(200);
    chk(done_cnt - n == 2, "R7 queued request", done_cnt - n, 2);
  endtask

  task automatic t_os_ignored();
    int n;
    res_code = 0; pwr_down = 0;
    wait_dones(2);
    step(1);
    single_req = 1; step(1); single_req = 0;
    pwr_down = 1; n = done_cnt;
    step(100);
    chk(done_cnt - n == 1, "R8 request ignored when running", done_cnt - n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lengths();
    t_extremes();
    t_gap();
    t_pulse();
    t_resmid();
    t_walk();
    t_shutdown();
    t_oneshot();
    t_os_ignored();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule